// File: doc/BRIEF.md
# Pipeline Precise Exception Controller

This block is the trap control for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Three stages can report a fault: decode flags an undefined instruction, execute flags an arithmetic overflow, and memory flags an address error. The controller keeps its own copy of the incremented PC and a valid bit for every stage behind fetch. It can therefore name the faulting instruction's address after that instruction has left fetch.

When a fault is accepted, the controller squashes the faulting instruction and everything younger than it. It does this through per-stage kill outputs, which the datapath uses to disable register and memory writes. Older instructions still drain to commit. On the same clock edge the controller loads the exception PC register and a one-flag cause word, and raises a one-cycle redirect. The redirect carries a handler address chosen from the fault type. Fetch starts the handler on the cycle after the fault.

Top module: `precise_exc_ctrl`

## Requirements
- R1: After reset, commit_valid, redirect_valid, all four kill outputs, epc and cause are all zero.
- R2: An instruction fetched with fetch_valid high in cycle N, and never squashed, shows commit_valid high in cycle N+4, with commit_pc equal to its fetch_pc_next minus 4.
- R3: A fault accepted in cycle N makes redirect_valid high in cycle N+1, with redirect_pc equal to the handler address. The handler addresses are 0xC0000000 for undefined instruction, 0xC0000020 for overflow and 0xC0000040 for address error.
- R4: After an accepted fault, cause holds exactly one set bit and all other bits are zero. The bit is 10 for undefined instruction, 5 for overflow and 4 for address error.
- R5: After an accepted fault, epc equals the faulting instruction's incremented PC minus 4.
- R6: In the cycle a fault is accepted in some stage, the kill outputs for that stage and every shallower stage (including kill_if) are high, and kill outputs of deeper stages are low; with no accepted fault all kill outputs are low.
- R7: A squashed instruction never raises commit_valid. Instructions deeper than the faulting stage still commit in their normal cycle.
- R8: When several stages report a fault in the same cycle, the deepest stage with a valid instruction wins. epc and cause then come from that instruction only.
- R9: A fault request from a stage that holds a bubble is ignored: no kill, no redirect, and epc and cause keep their values.
- R10: epc and cause keep their values in every cycle without an accepted fault.
- R11: redirect_valid is low in any cycle that does not directly follow an accepted fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| fetch_pc_next | input | 32 | Incremented PC (PC+4) of the fetched instruction |
| id_undef_req | input | 1 | Decode reports an undefined instruction |
| ex_ovf_req | input | 1 | Execute reports an arithmetic overflow |
| mem_addr_req | input | 1 | Memory reports an address error |
| kill_if | output | 1 | Squash the instruction in fetch |
| kill_id | output | 1 | Squash the instruction in decode |
| kill_ex | output | 1 | Squash the instruction in execute |
| kill_mem | output | 1 | Squash the instruction in memory (memory write off) |
| commit_valid | output | 1 | Write-back holds a live instruction |
| commit_pc | output | 32 | PC of the instruction in write-back |
| redirect_valid | output | 1 | Fetch must load redirect_pc this cycle |
| redirect_pc | output | 32 | Handler address for the last accepted fault |
| epc | output | 32 | PC of the last faulting instruction |
| cause | output | 32 | One-flag cause word of the last fault |

## Verification
Two things can happen in the same cycle. Several stages can raise a fault together, and younger stages can hold bubbles while their request lines are still toggling. The bench provokes both with random request lines and a random fetch pattern. It also runs directed cycles that raise all three faults at once on a full pipeline, and raise faults on an empty one. A bench-side stage model picks the deepest live requester. The bench then checks that the kill pattern, the exception PC, the cause flag and the handler address all belong to that one instruction, and that a request over a bubble leaves every output untouched.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int XLEN   = 32;
  localparam int NSTG   = 4;            // decode, execute, memory, write-back
  localparam int NFAULT = NSTG - 1;     // stages that can raise a fault
  localparam int SRC_W  = $clog2(NFAULT);

  typedef logic [XLEN-1:0] addr_t;

  // Fault code equals the index of the stage that raises it.
  typedef enum logic [1:0] {
    FLT_UNDEF = 2'd0,
    FLT_OVF   = 2'd1,
    FLT_ADDR  = 2'd2,
    FLT_NONE  = 2'd3
  } flt_code_e;

  localparam int CAUSE_BIT_UNDEF = 10;
  localparam int CAUSE_BIT_OVF   = 5;
  localparam int CAUSE_BIT_ADDR  = 4;

  function automatic flt_code_e code_of_stage(input logic [SRC_W-1:0] stg);
    case (stg)
      2'd0:    return FLT_UNDEF;
      2'd1:    return FLT_OVF;
      2'd2:    return FLT_ADDR;
      default: return FLT_NONE;
    endcase
  endfunction

  function automatic addr_t cause_word(input flt_code_e c);
    addr_t w;
    w = '0;
    case (c)
      FLT_UNDEF: w[CAUSE_BIT_UNDEF] = 1'b1;
      FLT_OVF:   w[CAUSE_BIT_OVF]   = 1'b1;
      FLT_ADDR:  w[CAUSE_BIT_ADDR]  = 1'b1;
      default:   w = '0;
    endcase
    return w;
  endfunction

  function automatic addr_t handler_addr(input addr_t base, input addr_t stride,
                                         input flt_code_e c);
    return base + stride * addr_t'(c);
  endfunction

  function automatic addr_t pc_of_next(input addr_t pcn, input addr_t step);
    return pcn - step;
  endfunction
endpackage

// File: rtl/exc_stage_track.sv
module exc_stage_track
  import exc_ctrl_pkg::*;
#(
  parameter int NS = NSTG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  addr_t                in_pcn,
  input  logic                 kill_in,
  input  logic [NS-2:0]        kill_stg,
  output logic [NS-1:0]        stg_v,
  output addr_t [NS-1:0]       stg_pcn
);
  logic [NS-1:0]  v_q;
  addr_t [NS-1:0] pcn_q;

  for (genvar i = 0; i < NS; i++) begin : g_stg
    logic  nxt_v;
    addr_t nxt_pcn;
    if (i == 0) begin : g_head
      assign nxt_v   = in_valid & ~kill_in;
      assign nxt_pcn = in_pcn;
    end else begin : g_body
      assign nxt_v   = v_q[i-1] & ~kill_stg[i-1];
      assign nxt_pcn = pcn_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[i]   <= 1'b0;
        pcn_q[i] <= '0;
      end else begin
        v_q[i]   <= nxt_v;
        pcn_q[i] <= nxt_pcn;
      end
    end
  end

  assign stg_v   = v_q;
  assign stg_pcn = pcn_q;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_ctrl_pkg::*;
#(
  parameter int NK = NFAULT
) (
  input  logic [NK-1:0]    stg_v,
  input  logic [NK-1:0]    req,
  output logic             take,
  output logic [SRC_W-1:0] src,
  output flt_code_e        code,
  output logic [NK-1:0]    kill_stg
);
  // Deeper index overrides shallower: the oldest live requester wins.
  always_comb begin
    take = 1'b0;
    src  = '0;
    for (int i = 0; i < NK; i++) begin
      if (req[i] && stg_v[i]) begin
        take = 1'b1;
        src  = SRC_W'(i);
      end
    end
  end

  assign code = take ? code_of_stage(src) : FLT_NONE;

  for (genvar k = 0; k < NK; k++) begin : g_kill
    assign kill_stg[k] = take && (SRC_W'(k) <= src);
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_ctrl_pkg::*;
#(
  parameter addr_t VEC_BASE   = 32'hC000_0000,
  parameter addr_t VEC_STRIDE = 32'h0000_0020,
  parameter addr_t INSN_BYTES = 32'd4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  flt_code_e code,
  input  addr_t     fault_pcn,
  output logic      redirect_valid,
  output addr_t     redirect_pc,
  output addr_t     epc,
  output addr_t     cause
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      epc            <= '0;
      cause          <= '0;
    end else begin
      redirect_valid <= take;
      if (take) begin
        redirect_pc <= handler_addr(VEC_BASE, VEC_STRIDE, code);
        epc         <= pc_of_next(fault_pcn, INSN_BYTES);
        cause       <= cause_word(code);
      end
    end
  end
endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter addr_t VEC_BASE   = 32'hC000_0000,
  parameter addr_t VEC_STRIDE = 32'h0000_0020,
  parameter addr_t INSN_BYTES = 32'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_valid,
  input  logic [31:0] fetch_pc_next,
  input  logic        id_undef_req,
  input  logic        ex_ovf_req,
  input  logic        mem_addr_req,
  output logic        kill_if,
  output logic        kill_id,
  output logic        kill_ex,
  output logic        kill_mem,
  output logic        commit_valid,
  output logic [31:0] commit_pc,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic [31:0] epc,
  output logic [31:0] cause
);
  localparam int ST_WB = NSTG - 1;

  logic [NSTG-1:0]    stg_v;
  addr_t [NSTG-1:0]   stg_pcn;
  logic [NFAULT-1:0]  flt_req;
  logic [NFAULT-1:0]  kill_stg;
  logic               flt_take;
  logic [SRC_W-1:0]   flt_src;
  flt_code_e          flt_code;
  addr_t              fault_pcn;

  assign flt_req = {mem_addr_req, ex_ovf_req, id_undef_req};

  exc_stage_track #(.NS(NSTG)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (fetch_valid),
    .in_pcn   (fetch_pc_next),
    .kill_in  (flt_take),
    .kill_stg (kill_stg),
    .stg_v    (stg_v),
    .stg_pcn  (stg_pcn)
  );

  exc_arbiter #(.NK(NFAULT)) u_arb (
    .stg_v    (stg_v[NFAULT-1:0]),
    .req      (flt_req),
    .take     (flt_take),
    .src      (flt_src),
    .code     (flt_code),
    .kill_stg (kill_stg)
  );

  assign fault_pcn = stg_pcn[flt_src];

  exc_state_regs #(
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE),
    .INSN_BYTES (INSN_BYTES)
  ) u_state (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (flt_take),
    .code           (flt_code),
    .fault_pcn      (fault_pcn),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .epc            (epc),
    .cause          (cause)
  );

  assign kill_if      = flt_take;
  assign kill_id      = kill_stg[0];
  assign kill_ex      = kill_stg[1];
  assign kill_mem     = kill_stg[2];
  assign commit_valid = stg_v[ST_WB];
  assign commit_pc    = pc_of_next(stg_pcn[ST_WB], INSN_BYTES);
endmodule

// File: rtl/precise_exc_ctrl_checker.sv
module precise_exc_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        kill_if,
  input logic        kill_id,
  input logic        kill_ex,
  input logic        kill_mem,
  input logic        commit_valid,
  input logic        redirect_valid,
  input logic [31:0] epc,
  input logic [31:0] cause,
  input logic [3:0]  stg_v
);
  a_r6_kill_chain: assert property (@(posedge clk) disable iff (!rst_n)
    kill_mem |-> (kill_ex && kill_id && kill_if));

  a_r3_redirect_follows: assert property (@(posedge clk) disable iff (!rst_n)
    kill_if |=> redirect_valid);

  a_r11_redirect_only_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(kill_if));

  a_r4_cause_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $onehot(cause));

  a_r7_no_commit_after_mem_flush: assert property (@(posedge clk) disable iff (!rst_n)
    kill_mem |=> !commit_valid);

  a_r9_empty_pipe_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_v[2:0] == 3'b000) |-> !kill_if);

  a_r10_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !kill_if |=> ($stable(epc) && $stable(cause)));
endmodule

bind precise_exc_ctrl precise_exc_ctrl_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .kill_if        (kill_if),
  .kill_id        (kill_id),
  .kill_ex        (kill_ex),
  .kill_mem       (kill_mem),
  .commit_valid   (commit_valid),
  .redirect_valid (redirect_valid),
  .epc            (epc),
  .cause          (cause),
  .stg_v          (stg_v)
);

// File: tb/precise_exc_ctrl_tb_top.sv
module precise_exc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc_next = '0;
  logic        id_undef_req = 1'b0, ex_ovf_req = 1'b0, mem_addr_req = 1'b0;
  logic        kill_if, kill_id, kill_ex, kill_mem;
  logic        commit_valid, redirect_valid;
  logic [31:0] commit_pc, redirect_pc, epc, cause;

  always #10 clk = ~clk;

  precise_exc_ctrl dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench-side stage model: 0=decode 1=execute 2=memory 3=write-back
  bit          mv [4];
  logic [31:0] mp [4];
  bit          m_rv;
  logic [31:0] m_rpc, m_epc, m_cause;
  logic [31:0] pc;

  function automatic logic [31:0] exp_vec(int st);
    return 32'hC000_0000 + 32'h20 * st;
  endfunction

  function automatic logic [31:0] exp_cause(int st);
    case (st)
      0: return 32'h1 << 10;
      1: return 32'h1 << 5;
      default: return 32'h1 << 4;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Entered at a negedge; returns at the next negedge.
  task automatic step(bit fv, logic [31:0] pcn, bit rid, bit rex, bit rmem);
    int w;
    bit anyreq;
    chk("R2 commit_valid", {31'b0, commit_valid}, {31'b0, mv[3]});
    if (mv[3]) chk("R2 commit_pc", commit_pc, mp[3] - 32'd4);
    chk(m_rv ? "R3 redirect_valid" : "R11 redirect_valid",
        {31'b0, redirect_valid}, {31'b0, m_rv});
    if (m_rv) chk("R3 redirect_pc", redirect_pc, m_rpc);
    chk(m_rv ? "R5 epc" : "R10 epc", epc, m_epc);
    chk(m_rv ? "R4 cause" : "R10 cause", cause, m_cause);

    fetch_valid = fv; fetch_pc_next = pcn;
    id_undef_req = rid; ex_ovf_req = rex; mem_addr_req = rmem;
    #1;
    w = -1;
    if (rid && mv[0]) w = 0;
    if (rex && mv[1]) w = 1;
    if (rmem && mv[2]) w = 2;
    anyreq = rid | rex | rmem;
    chk((anyreq && w < 0) ? "R9 kill_if" : "R6 kill_if", {31'b0, kill_if}, {31'b0, w >= 0});
    chk((anyreq && w < 0) ? "R9 kill_id" : "R6 kill_id", {31'b0, kill_id}, {31'b0, w >= 0});
    chk("R6 kill_ex", {31'b0, kill_ex}, {31'b0, w >= 1});
    chk("R6 kill_mem", {31'b0, kill_mem}, {31'b0, w >= 2});

    mv[3] = mv[2] && !(w >= 2); mp[3] = mp[2];
    mv[2] = mv[1] && !(w >= 1); mp[2] = mp[1];
    mv[1] = mv[0] && !(w >= 0); mp[1] = mp[0];
    mv[0] = fv && (w < 0);      mp[0] = pcn;
    m_rv = (w >= 0);
    if (w >= 0) begin
      m_epc   = (w == 0 ? mp[1] : (w == 1 ? mp[2] : mp[3])) - 32'd4;
      m_cause = exp_cause(w);
      m_rpc   = exp_vec(w);
    end
    @(negedge clk);
  endtask

  task automatic next_pc(output logic [31:0] pcn);
    if (redirect_valid) pc = redirect_pc;
    pc = pc + 32'd4;
    pcn = pc;
  endtask

  task automatic fill(int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] p;
      next_pc(p);
      step(1, p, 0, 0, 0);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] p, exp_epc;
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mp[i] = '0; end
    m_rv = 0; m_rpc = '0; m_epc = '0; m_cause = '0; pc = 32'h0000_1000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 commit_valid", {31'b0, commit_valid}, 32'd0);
    chk("R1 redirect_valid", {31'b0, redirect_valid}, 32'd0);
    chk("R1 epc", epc, 32'd0);
    chk("R1 cause", cause, 32'd0);
    chk("R1 kills", {28'b0, kill_if, kill_id, kill_ex, kill_mem}, 32'd0);

    // R9 faults over an empty pipeline
    step(0, 32'd0, 1, 1, 1);
    chk("R9 no redirect", {31'b0, redirect_valid}, 32'd0);
    chk("R9 epc untouched", epc, 32'd0);

    // R8 all three at once on a full pipeline: memory stage wins
    fill(4);
    exp_epc = mp[2] - 32'd4;
    next_pc(p);
    step(1, p, 1, 1, 1);
    chk("R8 cause from deepest", cause, 32'h10);
    chk("R8 epc from deepest", epc, exp_epc);
    chk("R7 squashed mem not committed", {31'b0, commit_valid}, 32'd0);

    // execute fault: older memory-stage instruction still commits (R7)
    fill(4);
    exp_epc = mp[2] - 32'd4;
    next_pc(p);
    step(1, p, 1, 1, 0);
    chk("R7 older commits", {31'b0, commit_valid}, 32'd1);
    chk("R7 older commit pc", commit_pc, exp_epc);
    chk("R3 overflow vector", redirect_pc, 32'hC000_0020);

    // decode fault alone
    fill(4);
    next_pc(p);
    step(1, p, 1, 0, 0);
    chk("R3 undef vector", redirect_pc, 32'hC000_0000);
    chk("R4 undef cause", cause, 32'h400);

    // random mix
    for (int c = 0; c < 4000; c++) begin
      bit fv, rid, rex, rmem;
      fv   = ($urandom % 4) != 0;
      rid  = ($urandom % 10) == 0;
      rex  = ($urandom % 10) == 0;
      rmem = ($urandom % 10) == 0;
      next_pc(p);
      step(fv, p, rid, rex, rmem);
    end
    step(0, 32'd0, 0, 0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule